// File: doc/BRIEF.md
# Bisync Block Receive Framer

This block walks through one received binary-synchronous transmission block, one byte per strobe, while the station is sending or receiving text. For every byte it decides whether the byte is written to the receive buffer and whether it enters the CRC-16 accumulator. It also tracks text entry, DLE escapes and the two kinds of block-check bytes: those embedded after an intermediate terminator and those that close the block. When the block ends it records the terminating character and a completion status word.

The caller pulses `start_i` to begin an operation. It then presents received bytes with `byte_vld_i` and pulses `sync_i` whenever the receiver recognises a sync sequence. The buffer takes `byte_i` when `wr_byte_o` is high. When `wr_dle_o` is also high, the buffer first writes a DLE (0x10), which is a DLE that was held back in transparent text. With `monitor_i` high the block is walked with all its rules applied, but nothing is written. Byte codes are EBCDIC: SOH 0x01, STX 0x02, ETX 0x03, DLE 0x10, ITB 0x1F, ETB 0x26, ENQ 0x2D, SYN 0x32, EOT 0x37, NAK 0x3D, ACK0 0x70, ACK1 0x61, WACK 0x6B, RVI 0x7C.

Top module: `bsc_rx_framer`

## Requirements
- R1: After `start_i`, the status word reads 0x01 (bit0 busy), and the terminator register and the graphic count read zero. Bytes are ignored while not busy.
- R2: In non-text state, a byte in 0x40..0xFE is stored, increments the graphic count and sets status bit1.
- R3: The first SOH or STX in non-text state enters normal text, and DLE STX enters transparent text. The entering byte clears the CRC accumulator and is excluded from it. In normal text, DLE STX switches to transparent text.
- R4: In transparent text, every byte except DLE is stored and included. A DLE is held back and excluded from the CRC. DLE SYN is neither stored nor included. Any other DLE x writes the held DLE plus x, and includes x.
- R5: ETX or ETB ends the block in non-text or normal text, and DLE ETX or DLE ETB ends it in transparent text. The next two bytes are BCC bytes: included in the CRC but never stored. If the remainder is then nonzero, status bit2 is set. If the following byte (the first pad) has a low nibble other than 0xF, status bit3 is set. Busy clears on the byte after the first pad.
- R6: ITB (DLE ITB in transparent text) is followed by two unstored BCC bytes, which are checked as in R5. The CRC accumulator is then cleared and the previous text state resumes, except that DLE ITB resumes normal text.
- R7: ENQ (DLE ENQ in transparent text) in any state, and EOT, NAK or DLE followed by 0x60..0x7F in non-text state, end the block only if the next byte has low nibble 0xF; busy clears on that byte. Otherwise status bit4 is set, the prior state returns, and that next byte is processed normally.
- R8: In text states, EOT, NAK and DLE followed by 0x60..0x7F are stored as data and set status bit4. In transparent text, a bare ETX is data.
- R9: A DLE followed by anything other than STX, ETB, ETX, SYN, ENQ, DLE, ITB, EOT, RVI, WACK, ACK0 or ACK1 sets status bit5.
- R10: The terminator register holds the ending byte, with bit7 set when the byte came after a DLE.
- R11: With `monitor_i` high, no write strobe rises, and status and terminator behave as without it.
- R12: A long limit of LONG_CYC cycles restarts at start and at text entry. Once text is entered, a gap limit of GAP_CYC cycles restarts at each `sync_i`. On expiry the block sets status bit6 (long limit) or bit7 (gap limit) and clears busy.
- R13: The CRC is CRC-16 (x^16+x^15+x^2+1), processed LSB first, with initial value zero. `crc_en_o` is high for exactly the bytes included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| start_i | input | 1 | begin a receive operation |
| monitor_i | input | 1 | walk the block without writing |
| sync_i | input | 1 | sync sequence seen, restarts gap limit |
| byte_vld_i | input | 1 | received byte strobe |
| byte_i | input | 8 | received byte |
| wr_dle_o | output | 1 | write a held DLE ahead of byte_i |
| wr_byte_o | output | 1 | write byte_i to the buffer |
| crc_en_o | output | 1 | byte_i enters the CRC |
| btc_o | output | 8 | terminating character |
| status_o | output | 8 | busy, graphics, BCC, pad, control, SCC, long, gap |
| lgr_cnt_o | output | LGR_W | leading graphic count |

## Verification
Directed blocks cover the following cases:
- Graphics followed by a terminator, with a good pad and with a bad pad, which tells lookahead termination apart from early stopping.
- A transparent block holding DLE DLE, DLE SYN and a bare ETX, which separates transparent escapes from normal-text rules.
- Intermediate check blocks, which show that the accumulator is cleared and that the correct text state returns.
- Stray stop codes inside text, and undefined escape codes.

Randomised normal-text blocks with correct or corrupted check bytes compare the write count and the block-check status against values computed in the bench. Timed runs with and without sync pulses separate the two limits.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  localparam logic [7:0] C_SOH  = 8'h01;
  localparam logic [7:0] C_STX  = 8'h02;
  localparam logic [7:0] C_ETX  = 8'h03;
  localparam logic [7:0] C_DLE  = 8'h10;
  localparam logic [7:0] C_ITB  = 8'h1F;
  localparam logic [7:0] C_ETB  = 8'h26;
  localparam logic [7:0] C_ENQ  = 8'h2D;
  localparam logic [7:0] C_SYN  = 8'h32;
  localparam logic [7:0] C_EOT  = 8'h37;
  localparam logic [7:0] C_NAK  = 8'h3D;
  localparam logic [7:0] C_ACK1 = 8'h61;
  localparam logic [7:0] C_WACK = 8'h6B;
  localparam logic [7:0] C_ACK0 = 8'h70;
  localparam logic [7:0] C_RVI  = 8'h7C;

  localparam int ST_BUSY = 0;
  localparam int ST_LGR  = 1;
  localparam int ST_BCC  = 2;
  localparam int ST_PAD  = 3;
  localparam int ST_CTL  = 4;
  localparam int ST_SCC  = 5;
  localparam int ST_TLNG = 6;
  localparam int ST_TGAP = 7;
  localparam int ST_W    = 8;

  typedef enum logic [3:0] {
    S_NTX, S_TXT, S_TRN, S_IB1, S_IB2, S_FB1, S_FB2, S_FB3, S_FB4, S_PAD
  } rx_st_e;

  function automatic logic legal_scc(input logic [7:0] b);
    return b inside {C_STX, C_ETB, C_ETX, C_SYN, C_ENQ, C_DLE, C_ITB, C_EOT,
                     C_RVI, C_WACK, C_ACK0, C_ACK1};
  endfunction

  function automatic logic is_stick(input logic [7:0] b);
    return b[7:5] == 3'b011;
  endfunction
endpackage

// File: rtl/bsc_crc16.sv
module bsc_crc16 #(
  parameter logic [15:0] POLY_R = 16'hA001
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        en_i,
  input  logic [7:0]  byte_i,
  output logic [15:0] crc_next_o
);
  logic [15:0] crc_q;

  always_comb begin
    logic [15:0] c;
    c = crc_q ^ {8'h00, byte_i};
    for (int i = 0; i < 8; i++) c = c[0] ? ((c >> 1) ^ POLY_R) : (c >> 1);
    crc_next_o = c;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_q <= '0;
    else if (clr_i) crc_q <= '0;
    else if (en_i)  crc_q <= crc_next_o;
  end

  // R13
  crc_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> crc_q == 16'h0000);
endmodule

// File: rtl/bsc_timer.sv
module bsc_timer #(
  parameter int LIMIT = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic run_i,
  output logic expire_o
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  assign expire_o = run_i && !restart_i && cnt_q == LAST;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (run_i)     cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  // R12
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/bsc_rx_ctl.sv
module bsc_rx_ctl
  import bsc_pkg::*;
#(
  parameter int LGR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              monitor_i,
  input  logic              byte_vld_i,
  input  logic [7:0]        byte_i,
  input  logic [15:0]       crc_next_i,
  input  logic              to_long_i,
  input  logic              to_gap_i,
  output logic              crc_en_o,
  output logic              crc_clr_o,
  output logic              wr_dle_o,
  output logic              wr_byte_o,
  output logic              enter_o,
  output logic              in_text_o,
  output logic [7:0]        btc_o,
  output logic [ST_W-1:0]   status_o,
  output logic [LGR_W-1:0]  lgr_o
);
  localparam logic [LGR_W-1:0] LGR_MAX = '1;

  rx_st_e st_q, st_d, prev_q, prev_d, cur;
  logic dle_q, dle_d, txt_q, fire, d, pad_ok, decode;
  logic stb, sdle, inc, clr, enter, done, lgr_inc;
  logic [7:0] btc_q, btc_d, btc_val;
  logic [ST_W-1:0] status_q, setb;
  logic [LGR_W-1:0] lgr_q;

  assign fire    = byte_vld_i & status_q[ST_BUSY];
  assign d       = dle_q;
  assign pad_ok  = &byte_i[3:0];
  assign btc_val = d ? {1'b1, byte_i[6:0]} : byte_i;

  always_comb begin
    st_d = st_q; prev_d = prev_q; dle_d = dle_q; btc_d = btc_q;
    stb = 1'b0; sdle = 1'b0; inc = 1'b0; clr = 1'b0; enter = 1'b0;
    done = 1'b0; setb = '0; lgr_inc = 1'b0; decode = 1'b0; cur = st_q;
    if (fire) begin
      dle_d = 1'b0;
      case (st_q)
        S_IB1: begin inc = 1'b1; st_d = S_IB2; end
        S_IB2: begin
          inc = 1'b1; clr = 1'b1; st_d = prev_q;
          if (crc_next_i != '0) setb[ST_BCC] = 1'b1;
        end
        S_FB1: begin inc = 1'b1; st_d = S_FB2; end
        S_FB2: begin
          inc = 1'b1; st_d = S_FB3;
          if (crc_next_i != '0) setb[ST_BCC] = 1'b1;
        end
        S_FB3: begin
          if (!pad_ok) setb[ST_PAD] = 1'b1;
          st_d = S_FB4;
        end
        S_FB4: done = 1'b1;
        S_PAD: begin
          if (pad_ok) done = 1'b1;
          else begin setb[ST_CTL] = 1'b1; cur = prev_q; decode = 1'b1; end
        end
        default: decode = 1'b1;
      endcase
      if (decode) begin
        st_d = cur;
        if (cur == S_TRN && !d && byte_i != C_DLE) begin
          stb = 1'b1; inc = 1'b1;
        end else begin
          if (d && !legal_scc(byte_i)) setb[ST_SCC] = 1'b1;
          // held transparent DLE goes out with any escape but SYN
          sdle = (cur == S_TRN) && d && (byte_i != C_SYN);
          case (byte_i)
            C_SYN: stb = 1'b0;
            C_DLE: begin
              if (d || cur != S_TRN) begin stb = 1'b1; inc = 1'b1; end
              dle_d = !d;
            end
            C_SOH: begin
              stb = 1'b1; inc = 1'b1;
              if (cur == S_NTX) begin enter = 1'b1; st_d = S_TXT; end
            end
            C_STX: begin
              stb = 1'b1; inc = 1'b1;
              if (cur == S_NTX) begin enter = 1'b1; st_d = d ? S_TRN : S_TXT; end
              else if (cur == S_TXT && d) st_d = S_TRN;
            end
            C_ETX, C_ETB: begin
              stb = 1'b1; inc = 1'b1;
              if (cur == S_NTX) setb[ST_CTL] = 1'b1;
              if (cur != S_TRN || d) begin btc_d = btc_val; prev_d = cur; st_d = S_FB1; end
            end
            C_ITB: begin
              stb = 1'b1; inc = 1'b1;
              if (cur == S_NTX) setb[ST_CTL] = 1'b1;
              if (cur != S_TRN || d) begin
                prev_d = (cur == S_TRN) ? S_TXT : cur; st_d = S_IB1;
              end
            end
            C_ENQ: begin
              stb = 1'b1; inc = 1'b1;
              if (cur != S_TRN || d) begin btc_d = btc_val; prev_d = cur; st_d = S_PAD; end
            end
            C_EOT, C_NAK: begin
              stb = 1'b1; inc = 1'b1;
              if (cur == S_NTX) begin btc_d = btc_val; prev_d = cur; st_d = S_PAD; end
              else setb[ST_CTL] = 1'b1;
            end
            default: begin
              stb = 1'b1; inc = 1'b1;
              if (d && is_stick(byte_i)) begin
                if (cur == S_NTX) begin btc_d = btc_val; prev_d = cur; st_d = S_PAD; end
                else setb[ST_CTL] = 1'b1;
              end else if (cur == S_NTX && byte_i >= 8'h40 && byte_i != 8'hFF) begin
                lgr_inc = 1'b1; setb[ST_LGR] = 1'b1;
              end
            end
          endcase
        end
      end
    end
    if (enter) clr = 1'b1;
  end

  assign crc_en_o  = inc & ~enter;
  assign crc_clr_o = clr;
  assign wr_byte_o = stb & ~monitor_i;
  assign wr_dle_o  = sdle & ~monitor_i;
  assign enter_o   = enter;
  assign in_text_o = txt_q;
  assign btc_o     = btc_q;
  assign status_o  = status_q;
  assign lgr_o     = lgr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_NTX; prev_q <= S_NTX; dle_q <= 1'b0; btc_q <= '0;
      lgr_q <= '0; status_q <= '0; txt_q <= 1'b0;
    end else if (start_i) begin
      st_q <= S_NTX; prev_q <= S_NTX; dle_q <= 1'b0; btc_q <= '0;
      lgr_q <= '0; status_q <= ST_W'(1); txt_q <= 1'b0;
    end else begin
      st_q <= st_d; prev_q <= prev_d; dle_q <= dle_d; btc_q <= btc_d;
      status_q <= status_q | setb;
      if (lgr_inc && lgr_q != LGR_MAX) lgr_q <= lgr_q + 1'b1;
      if (enter) txt_q <= 1'b1;
      if (done) status_q[ST_BUSY] <= 1'b0;
      if (status_q[ST_BUSY] && to_long_i) begin
        status_q[ST_TLNG] <= 1'b1; status_q[ST_BUSY] <= 1'b0;
      end
      if (status_q[ST_BUSY] && to_gap_i) begin
        status_q[ST_TGAP] <= 1'b1; status_q[ST_BUSY] <= 1'b0;
      end
    end
  end

  // R1
  start_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> status_o == ST_W'(1) && lgr_o == '0 && btc_o == 8'h00);
  // R4
  trn_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && st_q == S_TRN && dle_q && byte_i == C_SYN) |-> !wr_byte_o && !wr_dle_o && !crc_en_o);
  // R5
  bcc_nostore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && (st_q == S_FB1 || st_q == S_FB2 || st_q == S_IB1 || st_q == S_IB2)) |-> !wr_byte_o && crc_en_o);
  // R5
  final_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && st_q == S_FB4 && !start_i) |=> !status_o[ST_BUSY]);
  // R1
  idle_stays_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!status_o[ST_BUSY] && !start_i) |=> !status_o[ST_BUSY] && $stable(btc_o));
endmodule

// File: rtl/bsc_rx_framer.sv
module bsc_rx_framer
  import bsc_pkg::*;
#(
  parameter int LONG_CYC = 150_000_000,
  parameter int GAP_CYC  = 100_000_000,
  parameter int LGR_W    = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             monitor_i,
  input  logic             sync_i,
  input  logic             byte_vld_i,
  input  logic [7:0]       byte_i,
  output logic             wr_dle_o,
  output logic             wr_byte_o,
  output logic             crc_en_o,
  output logic [7:0]       btc_o,
  output logic [7:0]       status_o,
  output logic [LGR_W-1:0] lgr_cnt_o
);
  logic [15:0] crc_next;
  logic crc_clr, enter, in_text, to_long, to_gap;
  logic [ST_W-1:0] status;

  bsc_rx_ctl #(.LGR_W(LGR_W)) i_ctl (
    .clk_i, .rst_ni, .start_i, .monitor_i, .byte_vld_i, .byte_i,
    .crc_next_i(crc_next), .to_long_i(to_long), .to_gap_i(to_gap),
    .crc_en_o, .crc_clr_o(crc_clr), .wr_dle_o, .wr_byte_o,
    .enter_o(enter), .in_text_o(in_text), .btc_o,
    .status_o(status), .lgr_o(lgr_cnt_o)
  );

  bsc_crc16 i_crc (
    .clk_i, .rst_ni, .clr_i(crc_clr), .en_i(crc_en_o), .byte_i,
    .crc_next_o(crc_next)
  );

  bsc_timer #(.LIMIT(LONG_CYC)) i_tlong (
    .clk_i, .rst_ni, .restart_i(start_i | enter),
    .run_i(status[ST_BUSY]), .expire_o(to_long)
  );

  bsc_timer #(.LIMIT(GAP_CYC)) i_tgap (
    .clk_i, .rst_ni, .restart_i(start_i | enter | sync_i),
    .run_i(status[ST_BUSY] & in_text), .expire_o(to_gap)
  );

  assign status_o = status;
endmodule

// File: tb/test_bsc_rx_framer.sv
module test_bsc_rx_framer;
  logic clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0, monitor_i = 1'b0;
  logic sync_i = 1'b0, byte_vld_i = 1'b0;
  logic [7:0] byte_i = 8'h00;
  logic wr_dle_o, wr_byte_o, crc_en_o;
  logic [7:0] btc_o, status_o;
  logic [4:0] lgr_cnt_o;

  int n_chk = 0, n_err = 0, n_wr = 0, n_crc = 0;
  bit finished = 0;

  always #10 clk_i = ~clk_i;

  bsc_rx_framer #(.LONG_CYC(400), .GAP_CYC(60), .LGR_W(5)) i_bsc_rx_framer (.*);

  function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {8'h00, b};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ 16'hA001) : (r >> 1);
    return r;
  endfunction

  function automatic logic [15:0] crc_of(input logic [7:0] q[$]);
    logic [15:0] c = 16'h0000;
    foreach (q[i]) c = crc_upd(c, q[i]);
    return c;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk_i);
    byte_vld_i = 1'b1; byte_i = b;
    #5;
    n_wr += int'(wr_byte_o) + int'(wr_dle_o);
    n_crc += int'(crc_en_o);
    @(posedge clk_i); #1;
    byte_vld_i = 1'b0;
  endtask

  task automatic send_q(input logic [7:0] q[$]);
    foreach (q[i]) send(q[i]);
  endtask

  task automatic send_bcc(input logic [15:0] c);
    send(c[7:0]); send(c[15:8]);
  endtask

  task automatic begin_op(input logic mon);
    @(negedge clk_i);
    start_i = 1'b1; monitor_i = mon;
    @(posedge clk_i); #1;
    start_i = 1'b0; n_wr = 0; n_crc = 0;
  endtask

  task automatic settle;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] q[$];
    logic [15:0] c, c2;
    int r;
    r = $urandom(32'd4711);
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    settle();
    check("R1 reset status", status_o, 8'h00);

    // R1 start state, R2 graphics, R7 ENQ good pad, R10 plain terminator
    begin_op(1'b0); settle();
    check("R1 start status", status_o, 8'h01);
    send(8'h41); send(8'h42);
    send(8'h2D); send(8'hFF); settle();
    check("R2 graphics writes", n_wr, 3);
    check("R2 graphic count", lgr_cnt_o, 2);
    check("R7 enq ends", status_o, 8'h02);
    check("R10 btc enq", btc_o, 8'h2D);
    send(8'h41); settle();
    check("R1 idle ignores bytes", lgr_cnt_o, 2);

    // R7 EOT with bad pad, then processing resumes
    begin_op(1'b0);
    send(8'h37); send(8'h40); settle();
    check("R7 bad pad keeps busy", status_o, 8'h13);
    send(8'h2D); send(8'hFF); settle();
    check("R7 bad pad status", status_o, 8'h12);
    check("R7 bad pad lgr", lgr_cnt_o, 1);
    check("R7 writes", n_wr, 3);

    // R3 R5 R13 normal text block
    begin_op(1'b0);
    q = '{8'hC1, 8'hC2, 8'h5A, 8'h03};
    send(8'h02); send_q(q); c = crc_of(q); send_bcc(c);
    settle();
    check("R5 busy after bcc", status_o, 8'h01);
    send(8'hFF); send(8'hFF); settle();
    check("R5 status good", status_o, 8'h00);
    check("R5 writes", n_wr, 5);
    check("R13 crc enables", n_crc, 6);
    check("R10 btc etx", btc_o, 8'h03);

    // R5 bad check, bad pad
    begin_op(1'b0);
    send(8'h02); send_q(q); send_bcc(c ^ 16'h0100); send(8'h0E); send(8'hFF); settle();
    check("R5 bcc and pad error", status_o, 8'h0C);

    // R4 R8 transparent block
    begin_op(1'b0);
    send(8'h10); send(8'h02); send(8'h41); send(8'h10); send(8'h10);
    send(8'h42); send(8'h10); send(8'h32); send(8'h43); send(8'h03);
    send(8'h44); send(8'h10); send(8'h03);
    q = '{8'h41, 8'h10, 8'h42, 8'h43, 8'h03, 8'h44, 8'h03};
    send_bcc(crc_of(q)); send(8'hFF); send(8'hFF); settle();
    check("R4 transparent status", status_o, 8'h00);
    check("R4 transparent writes", n_wr, 11);
    check("R10 btc dle etx", btc_o, 8'h83);

    // R6 ITB in normal text
    begin_op(1'b0);
    send(8'h02); send(8'h51); send(8'h52); send(8'h1F);
    send_bcc(crc_of('{8'h51, 8'h52, 8'h1F}));
    send(8'h53); send(8'h54); send(8'h03);
    send_bcc(crc_of('{8'h53, 8'h54, 8'h03})); send(8'hFF); send(8'hFF); settle();
    check("R6 itb status", status_o, 8'h00);
    check("R6 itb writes", n_wr, 7);

    // R6 DLE ITB returns to normal text: plain ETB must end it
    begin_op(1'b0);
    send(8'h10); send(8'h02); send(8'h61); send(8'h10); send(8'h1F);
    send_bcc(crc_of('{8'h61, 8'h1F}));
    send(8'h62); send(8'h26);
    send_bcc(crc_of('{8'h62, 8'h26})); send(8'hFF); send(8'hFF); settle();
    check("R6 dle itb status", status_o, 8'h00);
    check("R6 btc etb", btc_o, 8'h26);

    // R8 stop codes inside normal text
    begin_op(1'b0);
    q = '{8'h51, 8'h37, 8'h3D, 8'h10, 8'h70, 8'h52, 8'h03};
    send(8'h02); send_q(q); send_bcc(crc_of(q)); send(8'hFF); send(8'hFF); settle();
    check("R8 text stop codes", status_o, 8'h10);
    check("R8 writes", n_wr, 8);

    // R9 undefined escape
    begin_op(1'b0);
    send(8'h10); send(8'h05); send(8'h2D); send(8'hFF); settle();
    check("R9 bad scc", status_o, 8'h20);
    begin_op(1'b0);
    send(8'h10); send(8'h62); send(8'hFF); settle();
    check("R9 stick undefined", status_o, 8'h20);
    check("R10 btc dle stick", btc_o, 8'hE2);
    check("R7 stick writes", n_wr, 2);

    // R11 monitor mode
    begin_op(1'b1);
    q = '{8'hC1, 8'hC2, 8'h5A, 8'h03};
    send(8'h02); send_q(q); send_bcc(crc_of(q)); send(8'hFF); send(8'hFF); settle();
    check("R11 monitor writes", n_wr, 0);
    check("R11 monitor status", status_o, 8'h00);
    monitor_i = 1'b0;

    // R12 gap limit with sync keepalive
    begin_op(1'b0);
    send(8'h02);
    for (int k = 0; k < 5; k++) begin
      repeat (40) @(negedge clk_i);
      sync_i = 1'b1; @(negedge clk_i); sync_i = 1'b0;
    end
    check("R12 sync keeps busy", status_o, 8'h01);
    repeat (70) @(negedge clk_i);
    check("R12 gap expiry", status_o, 8'h80);

    // R12 long limit
    begin_op(1'b0);
    repeat (380) @(negedge clk_i);
    check("R12 long not yet", status_o, 8'h01);
    repeat (30) @(negedge clk_i);
    check("R12 long expiry", status_o, 8'h40);

    // R5 R13 random normal text blocks
    for (int b = 0; b < 40; b++) begin
      int n;
      bit bad;
      n = 1 + int'($urandom_range(19));
      bad = $urandom_range(1) == 1;
      q = {};
      for (int j = 0; j < n; j++) q.push_back(8'($urandom_range(8'hFE, 8'h40)));
      q.push_back(8'h03);
      c2 = crc_of(q);
      if (bad) c2 ^= 16'h0001;
      begin_op(1'b0);
      send(8'h02); send_q(q); send_bcc(c2); send(8'hFF); send(8'hFF); settle();
      check("R5 random status", status_o, bad ? 8'h04 : 8'h00);
      check("R13 random writes", n_wr, n + 2);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule